// File: doc/BRIEF.md
# Ten-to-two double-data-rate output serializer

This block takes one 10-bit symbol per pixel period on each of three data lanes and turns each symbol into a serial stream. The stream is cut into two-bit slices for a double-data-rate output register, which is clocked by a fast clock at five times the pixel rate. A fourth lane carries the pixel clock itself. It does this by serializing a fixed word whose first half is low and whose second half is high, so the lane toggles once per pixel period. At a 40 MHz pixel clock each lane carries 400 Mbit/s, and the output stage supports up to 840 Mbit/s.

The symbols are registered on the pixel clock. The fast domain picks them up only on its reload cycle, which comes a fixed number of fast edges after the pixel edge, so the sampled value has had time to settle. The fast clock and the pixel clock come from one frequency source and have a fixed phase relation. A phase counter in the fast domain counts five cycles per symbol and reloads every lane's shift register once per pixel period. The output register, the clock generation and the differential pads sit outside this block.

Top module: `ddr_word_serializer`

## Requirements
- R1: While `rst` is high at a fast rising edge, every bit of `outRise` and `outFall` is low after that edge, and the phase count restarts at zero.
- R2: The first reload occurs on the fifth fast rising edge after `rst` is released. After that, every fifth fast edge is a reload edge. A reload starts a new symbol on every lane at once.
- R3: In the k-th fast cycle after a reload (k = 0..4), each lane drives symbol bit 2k on its `outRise` bit and bit 2k+1 on its `outFall` bit. Bit 0 is sent first.
- R4: Each pixel rising edge must coincide with the fast edge that lies two fast edges before a reload. The symbol present on `dataIn` at that pixel edge is the one serialized from the following reload onward.
- R5: Changes on `dataIn` that happen between pixel rising edges have no effect on the serialized output.
- R6: Lane 3 is the clock lane, at output bit index NUM_CH. It repeats a symbol whose bits 0 to 4 are 0 and bits 5 to 9 are 1. Its rising-edge bits over the five cycles are therefore 0,0,0,1,1 and its falling-edge bits are 0,0,1,1,1.
- R7: Data lane c takes `dataIn[10c+9:10c]` and drives output bit c of `outRise` and `outFall`, independently of the other lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pixClk | input | 1 | Pixel-rate clock; symbols are captured on its rising edge |
| fastClk | input | 1 | Serializer clock at five times the pixel rate, phase related to pixClk |
| rst | input | 1 | Synchronous active-high reset, seen by both clock domains |
| dataIn | input | 30 | Three 10-bit symbols, lane c at bits 10c+9..10c |
| outRise | output | 4 | Bit for the rising half of the DDR register, one per lane; bit 3 is the clock lane |
| outFall | output | 4 | Bit for the falling half of the DDR register, one per lane; bit 3 is the clock lane |

## Verification
Every one of the 1024 codes is swept through every data lane, and each lane uses a different permutation of the codes. A swap of the rising and falling outputs, or a reversed bit order, therefore breaks the per-slice comparison at once. The reload cadence is tested from the first edge after reset: a phase counter that is off by one would shift every slice by a pair and put neighbouring symbols together. The input is replaced with its complement between pixel edges, so a transparent or fast-domain capture would show inverted symbols. The clock lane is compared slice by slice, which exposes an inverted or mirrored pattern.

// File: rtl/ser_pkg.sv
package ser_pkg;
  // Strobes from the phase control to the lane datapath
  typedef struct packed {
    logic load;   // copy captured symbols into the lane shifters
    logic shift;  // advance every lane by one bit pair
  } serStrobeT;
endpackage

// File: rtl/ser_capture.sv
module ser_capture #(
  parameter int NUM_CH = 3,
  parameter int WORD_W = 10
) (
  input  logic                       pixClk,
  input  logic                       rst,
  input  logic [NUM_CH*WORD_W-1:0]   dataIn,
  output logic [NUM_CH*WORD_W-1:0]   captFlat
);
  // Symbols are held for a full pixel period in the slow domain
  always_ff @(posedge pixClk) begin
    if (rst) captFlat <= '0;
    else     captFlat <= dataIn;
  end
endmodule

// File: rtl/ser_ctrl.sv
module ser_ctrl
  import ser_pkg::*;
#(
  parameter int RATIO = 5,
  localparam int PH_W = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic            fastClk,
  input  logic            rst,
  output serStrobeT       strobe,
  output logic [PH_W-1:0] phase
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(RATIO - 1);

  logic atLast;
  assign atLast = (phase == LAST_PH);

  always_ff @(posedge fastClk) begin
    if (rst)         phase <= '0;
    else if (atLast) phase <= '0;
    else             phase <= phase + 1'b1;
  end

  always_comb begin
    strobe.load  = !rst && atLast;
    strobe.shift = !rst && !atLast;
  end
endmodule

// File: rtl/ser_datapath.sv
module ser_datapath
  import ser_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int WORD_W = 10
) (
  input  logic                     fastClk,
  input  logic                     rst,
  input  serStrobeT                strobe,
  input  logic [NUM_CH*WORD_W-1:0] captFlat,
  output logic [NUM_CH:0]          outRise,
  output logic [NUM_CH:0]          outFall
);
  localparam int LANES = NUM_CH + 1;
  // Low half first, high half second: one toggle per symbol
  localparam logic [WORD_W-1:0] CLK_PATTERN = {WORD_W{1'b1}} << (WORD_W / 2);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] shiftReg;

    if (g < NUM_CH) begin : gData
      assign src = captFlat[g*WORD_W +: WORD_W];
    end else begin : gClk
      assign src = CLK_PATTERN;
    end

    always_ff @(posedge fastClk) begin
      if (rst)               shiftReg <= '0;
      else if (strobe.load)  shiftReg <= src;
      else if (strobe.shift) shiftReg <= shiftReg >> 2;
    end

    assign outRise[g] = shiftReg[0];
    assign outFall[g] = shiftReg[1];
  end
endmodule

// File: rtl/ddr_word_serializer.sv
module ddr_word_serializer
  import ser_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int WORD_W = 10
) (
  input  logic                     pixClk,
  input  logic                     fastClk,
  input  logic                     rst,
  input  logic [NUM_CH*WORD_W-1:0] dataIn,
  output logic [NUM_CH:0]          outRise,
  output logic [NUM_CH:0]          outFall
);
  localparam int RATIO = WORD_W / 2;
  localparam int PH_W  = (RATIO > 1) ? $clog2(RATIO) : 1;

  serStrobeT                  ctrlBus;
  logic [PH_W-1:0]            phase;
  logic [NUM_CH*WORD_W-1:0]   captFlat;

  ser_capture #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) i_capture (
    .pixClk  (pixClk),
    .rst     (rst),
    .dataIn  (dataIn),
    .captFlat(captFlat)
  );

  ser_ctrl #(.RATIO(RATIO)) i_ctrl (
    .fastClk(fastClk),
    .rst    (rst),
    .strobe (ctrlBus),
    .phase  (phase)
  );

  ser_datapath #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) i_datapath (
    .fastClk (fastClk),
    .rst     (rst),
    .strobe  (ctrlBus),
    .captFlat(captFlat),
    .outRise (outRise),
    .outFall (outFall)
  );
endmodule

// File: rtl/ser_checker.sv
module ser_checker #(
  parameter int NUM_CH = 3,
  parameter int WORD_W = 10,
  localparam int RATIO = WORD_W / 2,
  localparam int PH_W  = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input logic                     fastClk,
  input logic                     rst,
  input logic                     loadStrobe,
  input logic [PH_W-1:0]          phase,
  input logic [NUM_CH*WORD_W-1:0] captFlat,
  input logic [NUM_CH:0]          outRise,
  input logic [NUM_CH:0]          outFall
);
  logic [NUM_CH-1:0] captBit0, captBit1;
  for (genvar c = 0; c < NUM_CH; c++) begin : gBits
    assign captBit0[c] = captFlat[c*WORD_W];
    assign captBit1[c] = captFlat[c*WORD_W + 1];
  end

  assert_reset_low_R1: assert property (@(posedge fastClk)
    rst |=> (outRise == '0 && outFall == '0 && phase == '0));

  assert_phase_step_R2: assert property (@(posedge fastClk) disable iff (rst)
    (32'(phase) != RATIO - 1) |=> (phase == PH_W'($past(phase) + 1'b1)));

  assert_phase_range_R2: assert property (@(posedge fastClk) disable iff (rst)
    32'(phase) < RATIO);

  assert_load_restarts_R2: assert property (@(posedge fastClk) disable iff (rst)
    loadStrobe |=> (phase == '0 && !loadStrobe));

  assert_load_copy_R4: assert property (@(posedge fastClk) disable iff (rst)
    loadStrobe |=> (outRise[NUM_CH-1:0] == $past(captBit0) &&
                    outFall[NUM_CH-1:0] == $past(captBit1)));

  assert_clk_lane_low_R6: assert property (@(posedge fastClk) disable iff (rst)
    loadStrobe |=> (!outRise[NUM_CH] && !outFall[NUM_CH]));
endmodule

bind ddr_word_serializer ser_checker #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_serChecker (
  .fastClk   (fastClk),
  .rst       (rst),
  .loadStrobe(ctrlBus.load),
  .phase     (phase),
  .captFlat  (captFlat),
  .outRise   (outRise),
  .outFall   (outFall)
);

// File: tb/test_ddr_word_serializer.sv
module test_ddr_word_serializer;
  localparam int NCH    = 3;
  localparam int WW     = 10;
  localparam int NP     = WW / 2;
  localparam int NWORDS = 1024;

  logic pixClk = 1'b0;
  logic fastClk = 1'b0;
  logic rst = 1'b1;
  logic [NCH*WW-1:0] dataIn = '0;
  logic [NCH:0] outRise, outFall;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [WW-1:0] recon [NCH];

  always #5  fastClk = ~fastClk;   // 100 MHz serializer clock
  always #25 pixClk  = ~pixClk;    // one fifth of it, edges line up

  ddr_word_serializer #(.NUM_CH(NCH), .WORD_W(WW)) i_ddr_word_serializer (
    .pixClk (pixClk),
    .fastClk(fastClk),
    .rst    (rst),
    .dataIn (dataIn),
    .outRise(outRise),
    .outFall(outFall)
  );

  function automatic logic [WW-1:0] wordOf(int w, int c);
    if (w < 0) return '0;
    return WW'(w * (2 * c + 1) + c * 100);
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  initial begin : main
    logic [WW-1:0] e;
    int w, p;
    repeat (9) @(negedge fastClk);
    check("R1", int'({outRise, outFall}), 0, "outputs during reset");
    #12 rst = 1'b0;
    repeat (5) @(negedge fastClk);
    for (int j = 0; j < NP * (NWORDS + 1); j++) begin
      w = j / NP - 1;
      p = j % NP;
      for (int c = 0; c < NCH; c++) begin
        e = wordOf(w, c);
        check("R3", int'(outRise[c]), int'(e[2*p]), "rise slice");
        check("R3", int'(outFall[c]), int'(e[2*p+1]), "fall slice");
        recon[c][2*p]   = outRise[c];
        recon[c][2*p+1] = outFall[c];
        if (p == NP - 1)
          check(c == 0 ? "R4 R5" : "R7", int'(recon[c]), int'(e), "whole symbol");
      end
      check(p == 0 ? "R2" : "R6", int'(outRise[NCH]), int'(2*p >= NP), "clock lane rise");
      check("R6", int'(outFall[NCH]), int'(2*p + 1 >= NP), "clock lane fall");
      if (p == 0) begin
        for (int c = 0; c < NCH; c++) dataIn[c*WW +: WW] = wordOf(j / NP, c);
      end else if (p == 3) begin
        dataIn = ~dataIn;   // away from the pixel edge: must be ignored
      end
      @(negedge fastClk);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule